// File: doc/BRIEF.md
# Power-of-Two PI Loop Filter with One-Bit Oscillator Drive

This block is the digital loop filter of a second-order clock-recovery loop. Every clock it accepts a signed timing-error word and forms a proportional-plus-integral control value. The integral branch is a trapezoidal accumulator, which is the discrete-time form of an analog integrator mapped through the bilinear transform. Both loop gains are arithmetic right shifts, so the datapath holds no multiplier. Because the loop has an integrator, it follows a constant frequency offset as well as a phase offset.

The signed control value is moved to an unsigned code by flipping its sign bit, and its upper bits feed a first-order delta-sigma modulator. The modulator runs on the logic clock and produces a one-bit stream whose density of ones follows the code. Outside the chip, an RC low-pass turns that stream into the tuning voltage of a voltage-controlled crystal oscillator. After reset the integrator is empty and the code sits at mid-scale, so the oscillator starts at its centre frequency.

Top module: `lf_pi_sd_top`

## Requirements
- R1: While rst_n is low at a rising edge, and after that edge, ctrl_out is 0, dac_code is 16'h8000 and dsm_bit is 0.
- R2: At each rising edge the integrator takes the value I + floor((e[n] + e[n-1]) / 2^SHIFT_I). Here e[n] is err_in sampled at that edge, e[n-1] is err_in at the previous edge (0 after reset), and the division rounds toward minus infinity.
- R3: The integrator saturates at -2^23 and 2^23-1 and never wraps. Once it sits at a limit, error that pushes further past that limit leaves it there.
- R4: ctrl_out changes at the same edge that samples e[n]. Its new value is floor(e[n] / 2^SHIFT_P) plus the integrator value just updated by R2.
- R5: ctrl_out saturates at -2^23 and 2^23-1 rather than wrapping.
- R6: dac_code is ctrl_out[23] inverted, followed by ctrl_out[22:8]. That equals (ctrl_out + 2^23) >> 8, and it follows ctrl_out with no extra register.
- R7: At each rising edge the 16-bit modulator state S and the dac_code value present before that edge are added as 17-bit numbers. dsm_bit takes bit 16 of the sum, and S takes bits 15:0.
- R8: While dac_code is held constant, the number of ones on dsm_bit over any 65536 consecutive cycles differs from dac_code by at most 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| err_in | input | 16 | Signed two's-complement timing error, one word per clock |
| ctrl_out | output | 24 | Signed saturated proportional-plus-integral control value |
| dac_code | output | 16 | Offset-binary code fed to the modulator |
| dsm_bit | output | 1 | One-bit delta-sigma stream toward the external RC filter |

## Verification
A wrong integrator value does not stay hidden. It shifts ctrl_out at the very next edge, and through the combinational offset it moves dac_code in the same cycle. A broken saturation shows up as a sign flip on ctrl_out, and because dac_code inverts the sign bit, the code jumps across its full range. A wrong modulator accumulator or carry changes dsm_bit within one or two cycles. A density error built up over a whole 65536-cycle window can only be seen by counting ones against the held code.

// File: rtl/lf_pkg.sv
// Shared constants and helpers for the PI loop filter.
// Assumes: all arithmetic widths stay below 62 bits so longint holds them.
package lf_pkg;
    localparam int ERR_W_DEF   = 16;
    localparam int ACC_W_DEF   = 24;
    localparam int CODE_W_DEF  = 16;
    localparam int SHIFT_P_DEF = 1;
    localparam int SHIFT_I_DEF = 13;

    // Clamp a wide signed value into a signed w-bit range.
    function automatic longint clamp_signed(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction
endpackage

// File: rtl/lf_pi_core.sv
// Proportional-plus-integral core with shift gains.
// The integrator adds (e[n]+e[n-1]) >>> SHIFT_I each cycle, which is the
// trapezoidal integrator, and saturates at ACC_W signed limits. The output
// adds e[n] >>> SHIFT_P to the freshly updated integrator and saturates as well.
// Assumes: ACC_W > ERR_W and both stay below 62 bits.
module lf_pi_core
    import lf_pkg::*;
#(
    parameter int ERR_W   = ERR_W_DEF,
    parameter int ACC_W   = ACC_W_DEF,
    parameter int SHIFT_P = SHIFT_P_DEF,
    parameter int SHIFT_I = SHIFT_I_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_in,
    output logic signed [ACC_W-1:0] ctrl_out
);
    logic signed [ERR_W-1:0] e_prev_q;
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] ctrl_q;
    logic signed [ACC_W-1:0] integ_d;
    logic signed [ACC_W-1:0] ctrl_d;
    longint                  pair_sum;

    // Next integrator and output values in wide arithmetic, then clamped.
    always_comb begin
        longint inc;
        longint p_term;
        longint integ_w;
        pair_sum = longint'(err_in) + longint'(e_prev_q);
        inc      = pair_sum >>> SHIFT_I;
        p_term   = longint'(err_in) >>> SHIFT_P;
        integ_w  = clamp_signed(longint'(integ_q) + inc, ACC_W);
        integ_d  = ACC_W'(integ_w);
        ctrl_d   = ACC_W'(clamp_signed(integ_w + p_term, ACC_W));
    end

    // Registers: previous error, integrator, control output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_prev_q <= '0;
            integ_q  <= '0;
            ctrl_q   <= '0;
        end else begin
            e_prev_q <= err_in;
            integ_q  <= integ_d;
            ctrl_q   <= ctrl_d;
        end
    end

    assign ctrl_out = ctrl_q;

    // R3
    integ_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sum >= 0) |=> (integ_q >= $past(integ_q)));

    // R2
    integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sum == 0) |=> $stable(integ_q));
endmodule

// File: rtl/lf_sd_mod.sv
// First-order delta-sigma modulator: a W+1 bit add of state and code,
// carry out is the one-bit stream, low W bits are kept as new state.
// Assumes: code_in is unsigned offset binary.
module lf_sd_mod #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_in,
    output logic         bit_out
);
    logic [W-1:0] state_q;
    logic         bit_q;
    logic [W:0]   sum;

    // Wide add exposing the carry.
    assign sum = {1'b0, state_q} + {1'b0, code_in};

    // State and output bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            bit_q   <= 1'b0;
        end else begin
            state_q <= sum[W-1:0];
            bit_q   <= sum[W];
        end
    end

    assign bit_out = bit_q;

    // R7
    carry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bit_q == (state_q < $past(code_in))));
endmodule

// File: rtl/lf_pi_sd_top.sv
// Loop filter top: PI core, sign-flip offset to unsigned code, one-bit modulator.
// Assumes: ACC_W >= CODE_W; the code takes the upper CODE_W bits of the control.
module lf_pi_sd_top
    import lf_pkg::*;
#(
    parameter int ERR_W   = ERR_W_DEF,
    parameter int ACC_W   = ACC_W_DEF,
    parameter int CODE_W  = CODE_W_DEF,
    parameter int SHIFT_P = SHIFT_P_DEF,
    parameter int SHIFT_I = SHIFT_I_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_W-1:0]  err_in,
    output logic [ACC_W-1:0]  ctrl_out,
    output logic [CODE_W-1:0] dac_code,
    output logic              dsm_bit
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic signed [ACC_W-1:0] ctrl_s;

    lf_pi_core #(
        .ERR_W(ERR_W), .ACC_W(ACC_W), .SHIFT_P(SHIFT_P), .SHIFT_I(SHIFT_I)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .err_in($signed(err_in)), .ctrl_out(ctrl_s)
    );

    // Offset binary: invert the sign bit, keep the next CODE_W-1 bits.
    assign dac_code = {~ctrl_s[ACC_W-1], ctrl_s[ACC_W-2 -: CODE_W-1]};
    assign ctrl_out = ctrl_s;

    lf_sd_mod #(.W(CODE_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .code_in(dac_code), .bit_out(dsm_bit)
    );

    // R1
    reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dac_code == MID_CODE && !dsm_bit));
endmodule

// File: tb/tb_lf_pi_sd_top.sv
module tb_lf_pi_sd_top;
    localparam int ERR_W   = 16;
    localparam int ACC_W   = 24;
    localparam int CODE_W  = 16;
    localparam int SHIFT_P = 1;
    localparam int SHIFT_I = 4;   // reduced so saturation is reached quickly

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ERR_W-1:0]  err_in = '0;
    logic [ACC_W-1:0]  ctrl_out;
    logic [CODE_W-1:0] dac_code;
    logic              dsm_bit;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    longint m_eprev, m_integ, m_ctrl, m_state;
    int     m_bit;

    always #2.5 clk = ~clk;

    lf_pi_sd_top #(.ERR_W(ERR_W), .ACC_W(ACC_W), .CODE_W(CODE_W),
                   .SHIFT_P(SHIFT_P), .SHIFT_I(SHIFT_I)) dut (
        .clk(clk), .rst_n(rst_n), .err_in(err_in),
        .ctrl_out(ctrl_out), .dac_code(dac_code), .dsm_bit(dsm_bit));

    function automatic longint sat(input longint v);
        longint hi = (longint'(1) <<< (ACC_W - 1)) - 1;
        longint lo = -(longint'(1) <<< (ACC_W - 1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic longint code_of(input longint c);
        return (c + (longint'(1) <<< (ACC_W - 1))) >>> (ACC_W - CODE_W);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_eprev = 0; m_integ = 0; m_ctrl = 0; m_state = 0; m_bit = 0;
    endtask

    task automatic compare(input string ctrl_req);
        check(ctrl_req, longint'($signed(ctrl_out)), m_ctrl);
        check("R6", longint'(dac_code), code_of(m_ctrl));
        check("R7", longint'(dsm_bit), longint'(m_bit));
    endtask

    // Compare at the falling edge, then advance the model and drive the next error.
    task automatic step(input int e, input string ctrl_req);
        longint s;
        compare(ctrl_req);
        s       = m_state + code_of(m_ctrl);
        m_bit   = int'(s >>> CODE_W);
        m_state = s & ((longint'(1) <<< CODE_W) - 1);
        m_integ = sat(m_integ + ((longint'(e) + m_eprev) >>> SHIFT_I));
        m_ctrl  = sat(m_integ + (longint'(e) >>> SHIFT_P));
        m_eprev = longint'(e);
        err_in  = ERR_W'(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        err_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        // R1: values during reset
        check("R1", longint'(ctrl_out), 0);
        check("R1", longint'(dac_code), 32768);
        check("R1", longint'(dsm_bit), 0);
        rst_n = 1'b1;
    endtask

    function automatic int rnd_err(input int span);
        return int'($urandom_range(2 * span, 0)) - span;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int ones;
        int code_hold;
        void'($urandom(32'd1234));
        do_reset();
        // R2, R4: full-range random error
        for (int i = 0; i < 300; i++) step(rnd_err(32767), "R4");
        // R2: small errors, floor rounding of negative sums
        for (int i = 0; i < 300; i++) step(rnd_err(40), "R2");
        // R3, R5: positive saturation
        for (int i = 0; i < 2300; i++) step(32767, "R5");
        check("R5", longint'($signed(ctrl_out)), (longint'(1) <<< 23) - 1);
        check("R6", longint'(dac_code), 65535);
        // R3: integrator held at limit, a small negative step moves it down from there
        step(-64, "R3");
        step(-64, "R3");
        // R3, R5: negative saturation
        for (int i = 0; i < 4400; i++) step(-32768, "R5");
        check("R5", longint'($signed(ctrl_out)), -(longint'(1) <<< 23));
        check("R6", longint'(dac_code), 0);
        // mixed random after saturation
        for (int i = 0; i < 400; i++) step(rnd_err(32767), "R2");
        // R8: hold a non-mid code and count ones over 65536 cycles
        for (int i = 0; i < 200; i++) step(15000, "R4");
        for (int i = 0; i < 4; i++) step(0, "R4");
        code_hold = int'(dac_code);
        ones = 0;
        for (int i = 0; i < 65536; i++) begin
            ones += int'(dsm_bit);
            step(0, "R2");
        end
        checks++;
        if (ones > code_hold + 1 || ones < code_hold - 1) begin
            errors++;
            $display("FAIL R8: actual=%0d expected=%0d (+/-1)", ones, code_hold);
        end
        // R1: reset in mid-run returns to mid-scale
        do_reset();
        for (int i = 0; i < 20; i++) step(rnd_err(1000), "R4");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule